// File: doc/BRIEF.md
# ULPI Link Startup and Low-Power Sequencer

This block is the link-side control logic for a ULPI transceiver. It owns the stop line, the output enable of the 8-bit data bus and a small register-write engine. After reset it keeps the stop line high and the bus undriven until its own bring-up is finished and the transceiver has released the bus. When the transceiver hands the bus back, the block drives the idle byte in the turnaround cycle. It never leaves a stale receive command floating on the bus.

On a suspend request it turns off the session-end and VBUS-valid comparators. It clears their enables in both edge-interrupt registers, clears the ID-float enables, and then drops the suspend-control bit, which puts the transceiver into low-power mode. On a resume request it raises the stop line to restart the transceiver clock. It waits for the bus to be released and the clock to settle, writes the comparator enables back, and only then reports ready. A link reset during low-power mode wakes the transceiver the same way, because the stop line is high throughout reset.

Top module: `ulpi_link_seq`

## Requirements
- R1: While `rst_n` is low, `stp` is 1 and `data_oe` is 0.
- R2: After reset release, `stp` stays 1 and `data_oe` stays 0 for BOOT_CYCLES clock edges, and after that until `phy_dir` is low. `stp` then goes low on a clock edge. While `ready` is 1, `stp` is 0.
- R3: In the first cycle with `phy_dir` low after it was high (outside bring-up), `data_oe` is 1 and `data_out` is 8'h00.
- R4: A register write drives 2'b10 in bits 7:6 and the 6-bit address in bits 5:0 until `phy_nxt` is seen. It then drives the data byte until `phy_nxt` is seen, and then holds `stp` high for exactly one cycle with `data_out` at 8'h00.
- R5: If `phy_dir` rises while a write's command or data byte is on the bus, that write is abandoned and restarted from its command byte once `phy_dir` is low. It completes exactly once.
- R6: With PROTECT_OFF set, bring-up ends with one write to address 0x07 of IFC_CTRL with bit 7 set (default 8'h80), and `ready` rises only after it.
- R7: A suspend request in the ready state issues these writes in this order: 0x0D of RISE_EN with bits 1 and 3 cleared (default 8'h15), 0x10 of FALL_EN with bits 1 and 3 cleared (default 8'h15), 0x1D of CARKIT_EN with bits 0 and 1 cleared (default 8'h00), and last 0x04 of FCTRL with bit 6 cleared (default 8'h05).
- R8: After that last write, once `phy_dir` rises, `lp_active` is 1 and `stp` is 0 while `phy_dir` stays high.
- R9: A resume request in low-power mode raises `stp` in the next cycle and holds it until `phy_dir` falls. After SETTLE_CYCLES further edges, the block writes RISE_EN (default 8'h1F) to 0x0D and then FALL_EN (default 8'h1F) to 0x10, and only then raises `ready`.
- R10: A reset while the transceiver is in low-power mode drives `stp` high, which makes the transceiver drop `phy_dir`. Bring-up then completes as in R2 and R6.
- R11: Whenever `phy_dir` is high, `data_oe` is 0.
- R12: A resume request while `ready` is 1 has no effect: no write is issued, `ready` stays 1 and `stp` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the transceiver |
| rst_n | input | 1 | Asynchronous active-low link reset |
| phy_dir | input | 1 | Bus direction from the transceiver, high when it owns the bus |
| phy_nxt | input | 1 | Transceiver accepted the current byte |
| suspend_req | input | 1 | Request to enter low-power mode, sampled in the ready state |
| resume_req | input | 1 | Request to leave low-power mode, sampled in low-power mode |
| data_out | output | 8 | Byte driven onto the data bus |
| data_oe | output | 1 | Output enable of the data bus |
| stp | output | 1 | Stop line to the transceiver |
| ready | output | 1 | Block idle and able to accept a request |
| lp_active | output | 1 | Transceiver is in low-power mode |

## Verification
A bus-functional transceiver in the bench answers each command byte with `phy_nxt`, logs every completed write, raises `phy_dir` after the suspend write, and drops it a few cycles after it sees `stp` high. The write log is checked against a cold bring-up, a suspend with a `phy_dir` pulse injected on one command byte, a resume, and a reset taken during low-power mode. These separate a missing or reordered comparator write, a write that is lost or duplicated after an abort, and a bring-up that ignores a transceiver still holding the bus. Direct receive-command pulses and a stray resume in the ready state check the turnaround byte and show that requests outside their state do nothing.

// File: rtl/ulpi_seq_pkg.sv
package ulpi_seq_pkg;

    typedef enum logic [3:0] {
        S_BOOT,
        S_PROT,
        S_IDLE,
        S_SUS_RISE,
        S_SUS_FALL,
        S_SUS_CK,
        S_SUS_FC,
        S_LPM_WAIT,
        S_LPM,
        S_WAKE,
        S_SETTLE,
        S_RES_RISE,
        S_RES_FALL
    } seq_state_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_CMD,
        W_DATA,
        W_STOP,
        W_HOLD
    } wr_state_e;

    localparam logic [5:0] A_FUNC_CTRL = 6'h04;
    localparam logic [5:0] A_IFC_CTRL  = 6'h07;
    localparam logic [5:0] A_IE_RISE   = 6'h0D;
    localparam logic [5:0] A_IE_FALL   = 6'h10;
    localparam logic [5:0] A_CARKIT_IE = 6'h1D;

    localparam logic [7:0] CMP_MASK    = 8'h0A; // bit1 VBUS valid, bit3 session end
    localparam logic [7:0] IDFLT_MASK  = 8'h03; // ID float rise / fall
    localparam logic [7:0] SUSPEND_BIT = 8'h40;
    localparam logic [7:0] PROTECT_BIT = 8'h80;
    localparam logic [1:0] TX_REGWR    = 2'b10;

endpackage

// File: rtl/ulpi_regwr.sv
module ulpi_regwr
    import ulpi_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [5:0] addr,
    input  logic [7:0] wdata,
    input  logic       dir,
    input  logic       nxt,
    output logic [7:0] bus_out,
    output logic       stp_o,
    output logic       done
);

    typedef struct packed {
        wr_state_e st;
    } wr_regs_t;

    wr_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        bus_out = 8'h00;
        stp_o   = 1'b0;
        done    = 1'b0;
        case (r_q.st)
            W_IDLE: begin
                if (req && !dir) r_d.st = W_CMD;
            end
            W_CMD: begin
                bus_out = {TX_REGWR, addr};
                if (dir)      r_d.st = W_HOLD;
                else if (nxt) r_d.st = W_DATA;
            end
            W_DATA: begin
                bus_out = wdata;
                if (dir)      r_d.st = W_HOLD;
                else if (nxt) r_d.st = W_STOP;
            end
            W_STOP: begin
                stp_o   = 1'b1;
                done    = 1'b1;
                r_d.st  = W_IDLE;
            end
            W_HOLD: begin
                if (!dir) r_d.st = W_IDLE;
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: W_IDLE};
        else        r_q <= r_d;
    end

endmodule

// File: rtl/ulpi_seq_ctrl.sv
module ulpi_seq_ctrl
    import ulpi_seq_pkg::*;
#(
    parameter int         BOOT_CYCLES   = 16,
    parameter int         SETTLE_CYCLES = 8,
    parameter bit         PROTECT_OFF   = 1'b1,
    parameter bit         HOST_OTG      = 1'b1,
    parameter logic [7:0] RISE_EN       = 8'h1F,
    parameter logic [7:0] FALL_EN       = 8'h1F,
    parameter logic [7:0] CARKIT_EN     = 8'h03,
    parameter logic [7:0] FCTRL         = 8'h45,
    parameter logic [7:0] IFC_CTRL      = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir,
    input  logic       suspend_req,
    input  logic       resume_req,
    input  logic       wr_done,
    output logic       wr_req,
    output logic [5:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       hold_stp,
    output logic       boot_tri,
    output logic       ready,
    output logic       lp_active
);

    localparam int CNT_MAX = (BOOT_CYCLES > SETTLE_CYCLES) ? BOOT_CYCLES : SETTLE_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] BOOT_LAST   = CNT_W'(BOOT_CYCLES - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        wr_req   = 1'b0;
        wr_addr  = 6'h00;
        wr_data  = 8'h00;
        hold_stp = 1'b0;
        boot_tri = 1'b0;
        case (r_q.st)
            S_BOOT: begin
                hold_stp = 1'b1;
                boot_tri = 1'b1;
                if (r_q.cnt != BOOT_LAST) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (!dir) begin
                    r_d.cnt = '0;
                    r_d.st  = PROTECT_OFF ? S_PROT : S_IDLE;
                end
            end
            S_PROT: begin
                wr_req  = 1'b1;
                wr_addr = A_IFC_CTRL;
                wr_data = IFC_CTRL | PROTECT_BIT;
                if (wr_done) r_d.st = S_IDLE;
            end
            S_IDLE: begin
                if (suspend_req) r_d.st = S_SUS_RISE;
            end
            S_SUS_RISE: begin
                wr_req  = 1'b1;
                wr_addr = A_IE_RISE;
                wr_data = RISE_EN & ~CMP_MASK;
                if (wr_done) r_d.st = S_SUS_FALL;
            end
            S_SUS_FALL: begin
                wr_req  = 1'b1;
                wr_addr = A_IE_FALL;
                wr_data = FALL_EN & ~CMP_MASK;
                if (wr_done) r_d.st = S_SUS_CK;
            end
            S_SUS_CK: begin
                wr_req  = 1'b1;
                wr_addr = A_CARKIT_IE;
                wr_data = CARKIT_EN & ~IDFLT_MASK;
                if (wr_done) r_d.st = S_SUS_FC;
            end
            S_SUS_FC: begin
                wr_req  = 1'b1;
                wr_addr = A_FUNC_CTRL;
                wr_data = FCTRL & ~SUSPEND_BIT;
                if (wr_done) r_d.st = S_LPM_WAIT;
            end
            S_LPM_WAIT: begin
                if (dir) r_d.st = S_LPM;
            end
            S_LPM: begin
                if (resume_req) r_d.st = S_WAKE;
            end
            S_WAKE: begin
                hold_stp = 1'b1;
                if (!dir) begin
                    r_d.cnt = '0;
                    r_d.st  = S_SETTLE;
                end
            end
            S_SETTLE: begin
                if (r_q.cnt != SETTLE_LAST) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else begin
                    r_d.cnt = '0;
                    r_d.st  = HOST_OTG ? S_RES_RISE : S_IDLE;
                end
            end
            S_RES_RISE: begin
                wr_req  = 1'b1;
                wr_addr = A_IE_RISE;
                wr_data = RISE_EN;
                if (wr_done) r_d.st = S_RES_FALL;
            end
            S_RES_FALL: begin
                wr_req  = 1'b1;
                wr_addr = A_IE_FALL;
                wr_data = FALL_EN;
                if (wr_done) r_d.st = S_IDLE;
            end
            default: r_d = '{st: S_BOOT, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_BOOT, cnt: '0};
        else        r_q <= r_d;
    end

    assign ready     = (r_q.st == S_IDLE);
    assign lp_active = (r_q.st == S_LPM);

endmodule

// File: rtl/ulpi_link_seq.sv
module ulpi_link_seq
    import ulpi_seq_pkg::*;
#(
    parameter int         BOOT_CYCLES   = 16,
    parameter int         SETTLE_CYCLES = 8,
    parameter bit         PROTECT_OFF   = 1'b1,
    parameter bit         HOST_OTG      = 1'b1,
    parameter logic [7:0] RISE_EN       = 8'h1F,
    parameter logic [7:0] FALL_EN       = 8'h1F,
    parameter logic [7:0] CARKIT_EN     = 8'h03,
    parameter logic [7:0] FCTRL         = 8'h45,
    parameter logic [7:0] IFC_CTRL      = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phy_dir,
    input  logic       phy_nxt,
    input  logic       suspend_req,
    input  logic       resume_req,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       stp,
    output logic       ready,
    output logic       lp_active
);

    logic       wr_req, wr_done, eng_stp, hold_stp, boot_tri;
    logic [5:0] wr_addr;
    logic [7:0] wr_data, eng_bus;

    ulpi_seq_ctrl #(
        .BOOT_CYCLES  (BOOT_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .PROTECT_OFF  (PROTECT_OFF),
        .HOST_OTG     (HOST_OTG),
        .RISE_EN      (RISE_EN),
        .FALL_EN      (FALL_EN),
        .CARKIT_EN    (CARKIT_EN),
        .FCTRL        (FCTRL),
        .IFC_CTRL     (IFC_CTRL)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir        (phy_dir),
        .suspend_req(suspend_req),
        .resume_req (resume_req),
        .wr_done    (wr_done),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .hold_stp   (hold_stp),
        .boot_tri   (boot_tri),
        .ready      (ready),
        .lp_active  (lp_active)
    );

    ulpi_regwr u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (wr_req),
        .addr   (wr_addr),
        .wdata  (wr_data),
        .dir    (phy_dir),
        .nxt    (phy_nxt),
        .bus_out(eng_bus),
        .stp_o  (eng_stp),
        .done   (wr_done)
    );

    // Bus is driven whenever the transceiver does not own it, except during bring-up.
    assign data_oe  = !boot_tri && !phy_dir;
    assign data_out = data_oe ? eng_bus : 8'h00;
    assign stp      = hold_stp | eng_stp;

endmodule

// File: rtl/ulpi_link_seq_chk.sv
module ulpi_link_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phy_dir,
    input logic [7:0] data_out,
    input logic       data_oe,
    input logic       stp,
    input logic       ready,
    input logic       lp_active
);

    p_reset_safe_r1: assert property (@(posedge clk)
        !rst_n |-> (stp && !data_oe));

    p_ready_stp_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !stp);

    p_turnaround_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(phy_dir) && data_oe) |-> (data_out == 8'h00));

    p_lpm_stp_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_active && phy_dir) |-> !stp);

    p_dir_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        phy_dir |-> !data_oe);

endmodule

bind ulpi_link_seq ulpi_link_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phy_dir  (phy_dir),
    .data_out (data_out),
    .data_oe  (data_oe),
    .stp      (stp),
    .ready    (ready),
    .lp_active(lp_active)
);

// File: tb/tb_ulpi_link_seq.sv
module tb_ulpi_link_seq;

    localparam int CLK_PERIOD = 10;
    localparam int BOOT_N     = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phy_nxt = 1'b0;
    logic       suspend_req = 1'b0;
    logic       resume_req = 1'b0;
    logic       rx_dir = 1'b0;
    logic       abort_dir = 1'b0;
    logic       lpm_dir = 1'b0;
    logic       phy_dir;
    logic [7:0] data_out;
    logic       data_oe, stp, ready, lp_active;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    assign phy_dir = rx_dir | abort_dir | lpm_dir;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_link_seq #(.BOOT_CYCLES(BOOT_N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phy_dir    (phy_dir),
        .phy_nxt    (phy_nxt),
        .suspend_req(suspend_req),
        .resume_req (resume_req),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .stp        (stp),
        .ready      (ready),
        .lp_active  (lp_active)
    );

    // Transceiver model: write acceptance, logging, abort injection, low-power entry and wake.
    int         ph = 0;
    logic [5:0] cap_a = '0;
    logic [7:0] cap_d = '0;
    logic [5:0] log_a [32];
    logic [7:0] log_d [32];
    int         nlog = 0;
    int         abort_req = 0;
    int         abort_taken = 0;
    int         abort_hold = 0;
    int         lpm_pend = 0;
    int         wake_cnt = 0;

    always @(posedge clk) begin
        if (abort_dir) begin
            if (abort_hold == 1) abort_dir <= 1'b0;
            abort_hold <= abort_hold - 1;
        end
        if (lpm_pend > 0) begin
            if (lpm_pend == 1) lpm_dir <= 1'b1;
            lpm_pend <= lpm_pend - 1;
        end
        if (lpm_dir && stp && wake_cnt == 0) wake_cnt <= 3;
        if (wake_cnt > 0) begin
            if (wake_cnt == 1) lpm_dir <= 1'b0;
            wake_cnt <= wake_cnt - 1;
        end
        if (phy_dir) begin
            ph      <= 0;
            phy_nxt <= 1'b0;
        end else begin
            case (ph)
                0: if (data_oe && data_out[7:6] == 2'b10) begin
                    if (abort_req != abort_taken && data_out[5:0] == 6'h10 && !phy_nxt) begin
                        abort_taken <= abort_taken + 1;
                        abort_dir   <= 1'b1;
                        abort_hold  <= 2;
                    end else if (phy_nxt) begin
                        cap_a <= data_out[5:0];
                        ph    <= 1;
                    end else begin
                        phy_nxt <= 1'b1;
                    end
                end
                1: if (phy_nxt) begin
                    cap_d   <= data_out;
                    phy_nxt <= 1'b0;
                    ph      <= 2;
                end
                default: if (stp) begin
                    if (nlog < 32) begin
                        log_a[nlog] <= cap_a;
                        log_d[nlog] <= cap_d;
                    end
                    nlog <= nlog + 1;
                    ph   <= 0;
                    if (cap_a == 6'h04 && !cap_d[6]) lpm_pend <= 2;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input int idx, input logic [5:0] a, input logic [7:0] d, input string tag);
        if (idx >= nlog || idx >= 32) begin
            chk(1'b0, tag, nlog, idx + 1);
        end else begin
            chk(log_a[idx] == a, tag, int'(log_a[idx]), int'(a));
            chk(log_d[idx] == d, tag, int'(log_d[idx]), int'(d));
        end
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!ready && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(ready, tag, int'(ready), 1);
    endtask

    // R1, R2, R6: cold bring-up.
    task automatic t_bringup;
        int hi = 0;
        int base;
        @(negedge clk);
        chk(stp == 1'b1, "R1 stp high in reset", int'(stp), 1);
        chk(data_oe == 1'b0, "R1 bus tristate in reset", int'(data_oe), 0);
        base = nlog;
        rst_n = 1'b1;
        @(negedge clk);
        while (stp && !data_oe && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        chk(hi == BOOT_N - 1, "R2 stp high length after reset", hi, BOOT_N - 1);
        wait_ready("R6 ready after bring-up");
        chk(nlog - base == 1, "R6 single bring-up write", nlog - base, 1);
        chk_log(base, 6'h07, 8'h80, "R6 interface control write");
        chk(stp == 1'b0, "R2 stp low when ready", int'(stp), 0);
    endtask

    // R3, R11: receive-command turnaround.
    task automatic t_turnaround;
        @(negedge clk);
        rx_dir = 1'b1;
        @(negedge clk);
        chk(data_oe == 1'b0, "R11 bus released while dir high", int'(data_oe), 0);
        @(negedge clk);
        rx_dir = 1'b0;
        #1;
        chk(data_oe == 1'b1, "R3 bus driven in turnaround", int'(data_oe), 1);
        chk(data_out == 8'h00, "R3 idle byte in turnaround", int'(data_out), 0);
    endtask

    // R12: stray resume in ready state.
    task automatic t_stray_resume;
        int base = nlog;
        @(negedge clk);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(nlog == base, "R12 no write on stray resume", nlog - base, 0);
        chk(ready == 1'b1, "R12 still ready", int'(ready), 1);
        chk(stp == 1'b0, "R12 stp stays low", int'(stp), 0);
    endtask

    // Shared suspend entry; returns the log index of its first write.
    task automatic do_suspend(input bit inject, output int base);
        int  n = 0;
        logic prev_dir;
        base = nlog;
        if (inject) abort_req++;
        @(negedge clk);
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        chk(ready == 1'b0, "R7 suspend accepted", int'(ready), 0);
        prev_dir = phy_dir;
        while (!lp_active && n < 500) begin
            @(negedge clk);
            if (prev_dir && !phy_dir)
                chk(data_oe && data_out == 8'h00, "R3 idle after aborted write", int'(data_out), 0);
            prev_dir = phy_dir;
            n++;
        end
        chk(lp_active == 1'b1, "R8 low-power reached", int'(lp_active), 1);
    endtask

    // R4, R5, R7, R8: suspend with an injected direction change.
    task automatic t_suspend;
        int base;
        do_suspend(1'b1, base);
        chk(abort_taken == abort_req, "R5 abort was injected", abort_taken, abort_req);
        chk(nlog - base == 4, "R5 R7 four writes exactly once", nlog - base, 4);
        chk_log(base,     6'h0D, 8'h15, "R7 rising enables cleared");
        chk_log(base + 1, 6'h10, 8'h15, "R5 R7 falling enables cleared after retry");
        chk_log(base + 2, 6'h1D, 8'h00, "R7 id float enables cleared");
        chk_log(base + 3, 6'h04, 8'h05, "R4 R7 suspend bit cleared last");
        repeat (4) begin
            @(negedge clk);
            chk(stp == 1'b0 && phy_dir, "R8 stp low in low-power", int'(stp), 0);
        end
    endtask

    // R9: resume.
    task automatic t_resume;
        int base = nlog;
        int n = 0;
        @(negedge clk);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        chk(stp == 1'b1, "R9 stp raised for wake", int'(stp), 1);
        while (phy_dir && n < 50) begin
            chk(stp == 1'b1, "R9 stp held while dir high", int'(stp), 1);
            @(negedge clk);
            n++;
        end
        chk(phy_dir == 1'b0, "R9 transceiver released bus", int'(phy_dir), 0);
        chk(ready == 1'b0, "R9 not ready before restore", int'(ready), 0);
        wait_ready("R9 ready after restore");
        chk(nlog - base == 2, "R9 two restore writes", nlog - base, 2);
        chk_log(base,     6'h0D, 8'h1F, "R9 rising enables restored");
        chk_log(base + 1, 6'h10, 8'h1F, "R9 falling enables restored");
    endtask

    // R10: reset taken during low-power mode.
    task automatic t_warm_reset;
        int base;
        do_suspend(1'b0, base);
        chk(nlog - base == 4, "R10 suspend before warm reset", nlog - base, 4);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(stp == 1'b1, "R1 R10 stp high in warm reset", int'(stp), 1);
        repeat (8) @(negedge clk);
        chk(phy_dir == 1'b0, "R10 transceiver woken by stp", int'(phy_dir), 0);
        base = nlog;
        rst_n = 1'b1;
        wait_ready("R10 ready after warm reset");
        chk(nlog - base == 1, "R10 single bring-up write", nlog - base, 1);
        chk_log(base, 6'h07, 8'h80, "R6 R10 interface control rewritten");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_bringup();
        t_turnaround();
        t_stray_resume();
        t_suspend();
        t_resume();
        t_turnaround();
        t_warm_reset();
        repeat (5) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule